// File: doc/BRIEF.md
# Inbound Request Ordering Stall Gate

This block sits between an inbound packet-request stream and a DMA issue port. Each request carries a source ID, a destination ID, a two-bit priority, a posted/non-posted flag and a payload length of up to 256 bytes. The block forwards requests in arrival order. It keeps a small table of issued requests whose completion status has not yet returned. A request is held back while any outstanding entry has the same source ID, the same destination ID, and a priority at or above its own. Posted writes stay in the table until their completion arrives, just as non-posted requests do. Two senders that use different source IDs therefore proceed in parallel. Senders that share one source ID are serialized against their own earlier traffic.

Each issued request receives a table tag. The DMA side returns that tag to report completion. The block also marks each issued request as supervisor or user level. It does this by comparing the source ID with a single programmable supervisor-ID register.

Top module: `req_order_gate`

## Requirements
- R1: A request is not issued while any outstanding entry has the same source ID, the same destination ID, and a stored priority greater than or equal to the request's priority. A larger priority value means a higher priority. While stalled, both `in_ready` and `out_valid` are low.
- R2: A completion presented with `cmp_valid` and `cmp_tag` frees its entry at that clock edge. A request that conflicted only with that entry is issued in the next cycle. A request that still conflicts with another entry stays stalled.
- R3: Posted requests (`in_posted`=1) occupy a table entry until their completion, exactly like non-posted requests, and they stall later conflicting requests in the same way.
- R4: A request whose source ID or destination ID differs from every outstanding entry, or whose priority is above every matching entry's priority, is issued without waiting.
- R5: `out_super` is 1 exactly when `out_sid` equals the supervisor-ID register. Otherwise it is 0.
- R6: Source ID, destination ID, priority, posted flag and length (1 to 256, 9-bit field) reach the issue port unchanged.
- R7: When all 8 entries are outstanding, `in_ready` is low even for a request that has no ID conflict.
- R8: A request is issued only on a valid/ready handshake at both sides, in arrival order. `in_ready` is low while `out_ready` is low.
- R9: A supervisor-ID write through `sup_we` takes effect for requests issued after that clock edge. A request issued in the same cycle as the write uses the old value.
- R10: Synchronous active-high reset clears all table entries and sets the supervisor-ID register to 0.
- R11: Each issued request receives a 3-bit tag (`out_tag`) that is not held by any outstanding entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound request valid |
| in_ready | output | 1 | Inbound request accepted |
| in_sid | input | 8 | Request source ID |
| in_did | input | 8 | Request destination ID |
| in_pri | input | 2 | Request priority, larger is higher |
| in_posted | input | 1 | 1 for posted write |
| in_len | input | 9 | Payload length in bytes |
| out_valid | output | 1 | Issue request valid |
| out_ready | input | 1 | DMA side accepts request |
| out_sid | output | 8 | Issued source ID |
| out_did | output | 8 | Issued destination ID |
| out_pri | output | 2 | Issued priority |
| out_posted | output | 1 | Issued posted flag |
| out_len | output | 9 | Issued length |
| out_tag | output | 3 | Table tag of the issued request |
| out_super | output | 1 | Supervisor privilege marker |
| cmp_valid | input | 1 | Completion status valid |
| cmp_tag | input | 3 | Tag of the completed request |
| sup_we | input | 1 | Supervisor-ID register write enable |
| sup_wdata | input | 8 | Supervisor-ID write value |

## Verification
On every cycle, the assertions check the following: no request is issued against a stored matching entry with equal or higher priority; a full table refuses input; a tag is always taken from a free slot and becomes busy afterwards; a completion clears its slot; the supervisor marker follows a write only from the next edge. The bench scenarios show what needs history and ordering. These cover a stall that ends exactly one cycle after the completion, a partial release where a lower-priority entry remains, parallel progress for differing IDs, the same-cycle supervisor write, and backpressure from the issue side.

// File: rtl/req_order_gate.sv
module req_order_gate #(
  parameter int SID_W = 8,
  parameter int DID_W = 8,
  parameter int PRI_W = 2,
  parameter int LEN_W = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SID_W-1:0] in_sid,
  input  logic [DID_W-1:0] in_did,
  input  logic [PRI_W-1:0] in_pri,
  input  logic             in_posted,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SID_W-1:0] out_sid,
  output logic [DID_W-1:0] out_did,
  output logic [PRI_W-1:0] out_pri,
  output logic             out_posted,
  output logic [LEN_W-1:0] out_len,
  output logic [$clog2(DEPTH)-1:0] out_tag,
  output logic             out_super,
  input  logic             cmp_valid,
  input  logic [$clog2(DEPTH)-1:0] cmp_tag,
  input  logic             sup_we,
  input  logic [SID_W-1:0] sup_wdata
);
  localparam int TAG_W = $clog2(DEPTH);

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] hit;
  logic [SID_W-1:0] sid_q [DEPTH];
  logic [DID_W-1:0] did_q [DEPTH];
  logic [PRI_W-1:0] pri_q [DEPTH];
  logic [SID_W-1:0] sup_q;
  logic [TAG_W-1:0] free_idx;
  logic             full, blocked, fire;

  always_comb begin
    free_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (!vld[k]) free_idx = TAG_W'(k);
  end

  assign full      = &vld;
  assign blocked   = (|hit) || full;
  assign out_valid = in_valid && !blocked;
  assign in_ready  = out_ready && !blocked;
  assign fire      = in_valid && in_ready;

  assign out_sid    = in_sid;
  assign out_did    = in_did;
  assign out_pri    = in_pri;
  assign out_posted = in_posted;
  assign out_len    = in_len;
  assign out_tag    = free_idx;
  assign out_super  = (in_sid == sup_q);

  always_ff @(posedge clk) begin
    if (rst)         sup_q <= '0;
    else if (sup_we) sup_q <= sup_wdata;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign hit[i] = vld[i] && (sid_q[i] == in_sid) && (did_q[i] == in_did)
                    && (pri_q[i] >= in_pri);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
      end else if (fire && free_idx == TAG_W'(i)) begin
        vld[i]   <= 1'b1;
        sid_q[i] <= in_sid;
        did_q[i] <= in_did;
        pri_q[i] <= in_pri;
      end else if (cmp_valid && cmp_tag == TAG_W'(i)) begin
        vld[i] <= 1'b0;
      end
    end

    AST_NO_ID_CLASH: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |-> !(vld[i] && sid_q[i] == out_sid &&
        did_q[i] == out_did && pri_q[i] >= out_pri)); // R1
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    ($countones(vld) == DEPTH) |-> !in_ready); // R7
  AST_TAG_FREE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> !vld[out_tag]); // R11
  AST_TAG_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> vld[$past(out_tag)]); // R11
  AST_CMP_FREES: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && vld[cmp_tag]) |=> !vld[$past(cmp_tag)]); // R2
  AST_BOTH_SIDES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (out_valid && out_ready)); // R8
  AST_SUP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sup_we) && out_valid) |-> (out_super == (out_sid == $past(sup_wdata)))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (vld == '0 && sup_q == '0)); // R10
endmodule

// File: tb/test_req_order_gate.sv
module test_req_order_gate;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_posted = 0, out_ready = 1, cmp_valid = 0, sup_we = 0;
  logic [7:0] in_sid = 0, in_did = 0, sup_wdata = 0;
  logic [1:0] in_pri = 0;
  logic [8:0] in_len = 1;
  logic [2:0] cmp_tag = 0;
  logic in_ready, out_valid, out_posted, out_super;
  logic [7:0] out_sid, out_did;
  logic [1:0] out_pri;
  logic [8:0] out_len;
  logic [2:0] out_tag;

  int tests = 0, fails = 0;
  logic [28:0] exp_q[$];
  logic [2:0] tags[$];
  logic [7:0] busy = '0;
  logic [7:0] sup_model = 0;

  always #5 clk = ~clk;

  req_order_gate i_req_order_gate (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items when the design issues
  always begin
    @(negedge clk); #2;
    if (rst) busy = '0;
    else begin
      if (out_valid && out_ready) begin
        logic [28:0] got;
        got = {out_sid, out_did, out_pri, out_posted, out_len, out_super};
        if (exp_q.size() == 0) chk(0, "R8", "unexpected issue", 1, 0);
        else begin
          logic [28:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R6", "issued fields", int'(got), int'(e));
          chk(got[0] == e[0], "R5", "supervisor bit", got[0], e[0]);
        end
        chk(!busy[out_tag], "R11", "tag already busy", busy[out_tag], 0);
        busy[out_tag] = 1'b1;
        tags.push_back(out_tag);
      end
      if (cmp_valid) busy[cmp_tag] = 1'b0;
    end
  end

  task automatic present(input logic [7:0] s, d, input logic [1:0] p,
                         input logic po, input logic [8:0] l);
    in_sid = s; in_did = d; in_pri = p; in_posted = po; in_len = l; in_valid = 1;
  endtask

  task automatic send(input logic [7:0] s, d, input logic [1:0] p, input logic po,
                      input logic [8:0] l, input bit now, input string req,
                      output logic [2:0] t);
    present(s, d, p, po, l);
    for (int k = 0; k < 50; k++) begin
      #1;
      if (in_ready) break;
      if (now && k == 0) chk(0, req, "not issued at once", 0, 1);
      @(negedge clk);
    end
    exp_q.push_back({s, d, p, po, l, (s == sup_model)});
    @(negedge clk);
    in_valid = 0;
    t = tags[$];
  endtask

  task automatic stalled(input logic [7:0] s, d, input logic [1:0] p,
                         input logic po, input int n, input string req);
    present(s, d, p, po, 9'd64);
    for (int k = 0; k < n; k++) begin
      #1;
      chk(!in_ready && !out_valid, req, "stall expected", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic complete(input logic [2:0] t);
    cmp_valid = 1; cmp_tag = t;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic wr_sup(input logic [7:0] v);
    sup_we = 1; sup_wdata = v;
    @(negedge clk);
    sup_we = 0; sup_model = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] ta, tb, tc, td, te, tf, tg, th, ti, tj, tk, tl;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(!out_valid, "R10", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R10", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    send(8'd1, 8'd2, 2'd1, 1'b1, 9'd256, 1, "R6", ta);
    stalled(8'd1, 8'd2, 2'd1, 1'b1, 3, "R3");
    complete(ta);
    send(8'd1, 8'd2, 2'd1, 1'b1, 9'd128, 1, "R2", tb);
    stalled(8'd1, 8'd2, 2'd0, 1'b0, 3, "R1");
    send(8'd1, 8'd2, 2'd2, 1'b0, 9'd32, 1, "R4", tc);
    stalled(8'd1, 8'd2, 2'd2, 1'b1, 2, "R1");
    complete(tc);
    send(8'd1, 8'd2, 2'd2, 1'b1, 9'd16, 1, "R2", td);
    stalled(8'd1, 8'd2, 2'd1, 1'b0, 2, "R2");
    send(8'd5, 8'd2, 2'd3, 1'b1, 9'd8, 1, "R4", te);
    send(8'd1, 8'd9, 2'd0, 1'b1, 9'd4, 1, "R4", tf);

    wr_sup(8'd5);
    send(8'd5, 8'd3, 2'd0, 1'b0, 9'd2, 1, "R5", tg);
    send(8'd6, 8'd3, 2'd0, 1'b0, 9'd2, 1, "R5", th);
    // write and request in the same cycle: old value applies
    sup_we = 1; sup_wdata = 8'd7;
    present(8'd7, 8'd4, 2'd0, 1'b0, 9'd1);
    #1;
    chk(in_ready, "R9", "same-cycle request ready", in_ready, 1);
    chk(!out_super, "R9", "old supervisor value used", out_super, 0);
    exp_q.push_back({8'd7, 8'd4, 2'd0, 1'b0, 9'd1, 1'b0});
    @(negedge clk);
    sup_we = 0; in_valid = 0; sup_model = 8'd7;
    ti = tags[$];
    send(8'd7, 8'd4, 2'd1, 1'b0, 9'd1, 1, "R9", tj);

    stalled(8'd20, 8'd20, 2'd0, 1'b0, 3, "R7");
    complete(te);
    send(8'd20, 8'd20, 2'd0, 1'b0, 9'd200, 1, "R7", tk);

    complete(tb);
    out_ready = 0;
    present(8'd30, 8'd1, 2'd0, 1'b0, 9'd3);
    #1;
    chk(!in_ready, "R8", "in_ready while out_ready low", in_ready, 0);
    chk(out_valid, "R8", "out_valid offered", out_valid, 1);
    @(negedge clk);
    out_ready = 1;
    send(8'd30, 8'd1, 2'd0, 1'b0, 9'd3, 1, "R8", tl);

    foreach (tags[k]) if (busy[tags[k]]) complete(tags[k]);
    chk(busy == 0, "R11", "all tags released", busy, 0);

    send(8'd40, 8'd40, 2'd3, 1'b1, 9'd10, 1, "R4", ta);
    rst = 1;
    @(negedge clk);
    rst = 0; sup_model = 0;
    send(8'd40, 8'd40, 2'd0, 1'b1, 9'd10, 1, "R10", ta);
    send(8'd0, 8'd1, 2'd0, 1'b0, 9'd5, 1, "R10", tb);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "pending expected items", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule